// File: doc/BRIEF.md
# Buffered-Transmit SPI Controller

This block is an 8-bit serial peripheral controller that can act as bus master or as slave. One holding register sits in front of the shift register, so software can queue the next byte while the current one is being shifted. A register port gives access to control, status, data and the clock-rate setting. The four serial pins each have their own output enable, and a level interrupt reports receive, fault and transmit-empty conditions.

Software queues a byte in two steps. It first reads status and sees the transmit-empty flag set, and only then writes the data register. A write that was not preceded by such a read is dropped. In master mode the clock is the system clock divided by a power of two. When a byte is waiting, transfers follow one another without any idle gap. A queued byte moves into the shifter only at a transfer boundary. If a master whose select line is an input sees that line pulled low, it records a mode fault, drops back to slave mode and releases every pin driver.

Top module: `spi_buffered_ctrl`

## Requirements
- R1: Status (register 1) bit 0 is transmit-empty, which is 1 when the holding register is empty and 0 when it is full. Bit 1 is receive-full and bit 2 is mode-fault. After reset, control reads 0x00, status reads 0x01, every output enable is 0, the select output is 1 and irq is 0.
- R2: A data write (register 2) is accepted only if status was read with transmit-empty at 1 since the last data write. Any other data write changes nothing and starts no transfer.
- R3: Control (register 0) bit 2 sets the idle level of the serial clock. Bit 3 selects the phase: with 0, data is sampled on odd edges; with 1, it is sampled on even edges. A master sends the queued byte with MOSI valid at every sampling edge.
- R4: In master mode with phase 1, a waiting byte starts with no gap. Its first edge comes two half-periods after the previous byte's 16th edge, and the select output stays low in between.
- R5: A byte written while a master transfer is in progress stays in the holding register with transmit-empty at 0 until the next transfer boundary. It is then sent after the current byte.
- R6: At the end of a transfer the received byte is placed in the data register and receive-full is set. Receive-full clears only when data is read after a status read that saw it set. A data read on its own leaves it set.
- R7: Control bit 4 set makes the least significant bit go first, for both sending and receiving.
- R8: A mode fault occurs when enable (bit 0) and master (bit 1) are set, select-drive (bit 5) is clear, and the select input is low. It sets status bit 2, clears control bit 1 and forces all four output enables to 0. A later control write clears it.
- R9: In slave mode with phase 1, MISO is enabled while select is low and shows the transmitted byte most significant bit first. After the 16th clock edge MISO holds the last bit until the next edge, even when a new byte is queued.
- R10: The serial clock half-period is 2^N system clocks, where N is register 3 bits 2:0.
- R11: irq is set when enable is set and either receive-enable (control bit 6) is set with receive-full or mode-fault high, or transmit-enable (control bit 7) is set with transmit-empty high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 2 | Register select: 0 control, 1 status, 2 data, 3 rate |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data of the selected register |
| sck_o | output | 1 | Serial clock driven as master |
| sck_oe | output | 1 | Serial clock output enable |
| sck_i | input | 1 | Serial clock received as slave |
| mosi_o | output | 1 | Master data out |
| mosi_oe | output | 1 | Master data output enable |
| mosi_i | input | 1 | Data in as slave |
| miso_i | input | 1 | Data in as master |
| miso_o | output | 1 | Slave data out |
| miso_oe | output | 1 | Slave data output enable |
| ss_o | output | 1 | Select driven as master, low during transfers |
| ss_oe | output | 1 | Select output enable |
| ss_i | input | 1 | Select input |
| irq | output | 1 | Interrupt request |

## Verification
Two events can land in the same cycle: a software write into the holding register and the shifter's boundary handover. The bench places a status read and a data write inside the first clock pulse of a master transfer, at a slow rate so that the write is sure to fall mid-byte. It then checks that transmit-empty stays low for the rest of the byte and that the bytes come out in order. A second pairing is a slave boundary coinciding with a new byte queued after the 16th edge. That case is judged by watching MISO every cycle with select still low and requiring it to keep the last bit.

// File: rtl/spi_buffered_ctrl.sv
`timescale 1ns/1ps
module spi_buffered_ctrl #(
  parameter int DW = 8,
  parameter int RATE_W = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    reg_sel,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          sck_o,
  output logic          sck_oe,
  input  logic          sck_i,
  output logic          mosi_o,
  output logic          mosi_oe,
  input  logic          mosi_i,
  input  logic          miso_i,
  output logic          miso_o,
  output logic          miso_oe,
  output logic          ss_o,
  output logic          ss_oe,
  input  logic          ss_i,
  output logic          irq
);
  localparam int EDGES = 2 * DW;
  localparam int CW    = $clog2(EDGES + 1);
  localparam int DIV_W = 1 << RATE_W;

  logic [7:0]        ctrl;
  logic [RATE_W-1:0] rate;
  logic [DW-1:0]     buf_q, shreg, rx_q;
  logic              buf_full, rx_full, fault, tx_arm, rx_arm, busy, sck_ph, smp;
  logic [CW-1:0]     ecnt;
  logic [DIV_W-1:0]  div;
  logic [2:0]        sck_s, ss_s;
  logic [1:0]        mosi_s;

  wire en     = ctrl[0];
  wire mst    = ctrl[1];
  wire cpol   = ctrl[2];
  wire cpha   = ctrl[3];
  wire lsb    = ctrl[4];
  wire ss_drv = ctrl[5];
  wire rx_ie  = ctrl[6];
  wire tx_ie  = ctrl[7];

  wire m_act    = en & mst & ~fault;
  wire s_act    = en & ~mst & ~fault;
  wire ss_now   = ss_s[1];
  wire sck_edge = sck_s[2] ^ sck_s[1];
  wire at_end   = (ecnt == CW'(EDGES));
  wire tick     = busy & (div == ((DIV_W'(1) << rate) - DIV_W'(1)));

  wire ev   = m_act ? (tick & ~at_end) : (s_act & sck_edge & ~ss_now & ~at_end);
  wire done = m_act ? (tick & at_end) : (s_act & at_end);
  wire smp_edge = cpha ? ecnt[0] : ~ecnt[0];
  wire sh_edge  = ~smp_edge & ~(cpha & (ecnt == '0));
  wire in_bit   = m_act ? miso_i : mosi_s[1];

  wire wr_ctrl = reg_wr & (reg_sel == 2'd0);
  wire wr_data = reg_wr & (reg_sel == 2'd2);
  wire wr_rate = reg_wr & (reg_sel == 2'd3);
  wire rd_stat = reg_rd & (reg_sel == 2'd1);
  wire rd_data = reg_rd & (reg_sel == 2'd2);
  wire data_ok = wr_data & tx_arm;

  wire mf     = en & mst & ~ss_drv & ~ss_now;
  wire m_load = m_act & buf_full & (~busy | done);
  wire s_load = s_act & buf_full & (cpha ? (ev & (ecnt == '0)) : (ss_s[2] & ~ss_now));
  wire load   = m_load | s_load;

  function automatic logic [DW-1:0] shf(input logic [DW-1:0] v, input logic b, input logic lf);
    return lf ? {b, v[DW-1:1]} : {v[DW-2:0], b};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0; rate <= '0; fault <= 1'b0;
      buf_q <= '0; buf_full <= 1'b0; tx_arm <= 1'b0;
      rx_q <= '0; rx_full <= 1'b0; rx_arm <= 1'b0;
      shreg <= '0; smp <= 1'b0; busy <= 1'b0; sck_ph <= 1'b0;
      ecnt <= '0; div <= '0;
      sck_s <= '0; ss_s <= '1; mosi_s <= '0;
    end else begin
      sck_s  <= {sck_s[1:0], sck_i};
      ss_s   <= {ss_s[1:0], ss_i};
      mosi_s <= {mosi_s[0], mosi_i};

      if (wr_ctrl) begin
        ctrl  <= reg_wdata[7:0];
        fault <= 1'b0;
      end
      if (mf) begin
        ctrl[1] <= 1'b0;
        fault   <= 1'b1;
      end
      if (wr_rate) rate <= reg_wdata[RATE_W-1:0];

      if (wr_data) tx_arm <= 1'b0;
      else if (rd_stat && !buf_full) tx_arm <= 1'b1;
      if (load) buf_full <= 1'b0;
      if (data_ok) begin
        buf_q    <= reg_wdata;
        buf_full <= 1'b1;
      end

      if (done) begin
        rx_full <= 1'b1;
        rx_q    <= cpha ? shf(shreg, smp, lsb) : shreg;
      end else if (rd_data && rx_arm) rx_full <= 1'b0;
      if (rd_data || done) rx_arm <= 1'b0;
      else if (rd_stat && rx_full) rx_arm <= 1'b1;

      if (!m_act && !s_act) begin
        busy <= 1'b0; ecnt <= '0; sck_ph <= 1'b0; div <= '0;
      end else begin
        if (busy) div <= tick ? '0 : div + 1'b1;
        if (s_act && ss_now) ecnt <= '0;
        if (ev) begin
          ecnt <= ecnt + 1'b1;
          if (m_act) sck_ph <= ~sck_ph;
          if (smp_edge) smp <= in_bit;
          if (sh_edge) shreg <= shf(shreg, smp, lsb);
        end
        if (done) begin
          ecnt   <= '0;
          sck_ph <= 1'b0;
          if (m_act && !buf_full) busy <= 1'b0;
        end
        if (load) shreg <= buf_q;
        if (m_load) begin
          busy <= 1'b1;
          if (!busy) div <= '0;
        end
      end
    end
  end

  wire out_bit = lsb ? shreg[0] : shreg[DW-1];

  assign sck_o   = cpol ^ sck_ph;
  assign sck_oe  = m_act;
  assign mosi_o  = out_bit;
  assign mosi_oe = m_act;
  assign miso_o  = out_bit;
  assign miso_oe = s_act & ~ss_now;
  assign ss_o    = ~busy;
  assign ss_oe   = m_act & ss_drv;
  assign irq     = en & ((rx_ie & (rx_full | fault)) | (tx_ie & ~buf_full));

  always_comb begin
    case (reg_sel)
      2'd0:    reg_rdata = DW'(ctrl);
      2'd1:    reg_rdata = DW'({fault, rx_full, ~buf_full});
      2'd2:    reg_rdata = rx_q;
      default: reg_rdata = DW'(rate);
    endcase
  end
endmodule

// File: rtl/spi_buffered_ctrl_chk.sv
`timescale 1ns/1ps
module spi_buffered_ctrl_chk #(
  parameter int CW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fault,
  input logic          sck_oe,
  input logic          mosi_oe,
  input logic          miso_oe,
  input logic          ss_oe,
  input logic          buf_full,
  input logic          wr_data,
  input logic          tx_arm,
  input logic          done,
  input logic          rx_full,
  input logic          m_act,
  input logic          s_act,
  input logic          busy,
  input logic [CW-1:0] ecnt,
  input logic          cpha,
  input logic          cpol,
  input logic [7:0]    ctrl,
  input logic          ev,
  input logic          miso_o,
  input logic          sck_o
);
  AST_FAULT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> !(sck_oe || mosi_oe || miso_oe || ss_oe)); // R8

  AST_UNARMED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data && !tx_arm && !buf_full) |=> !buf_full); // R2

  AST_HANDOVER_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    (m_act && busy && $past(m_act && busy) && ecnt != '0) |-> !$fell(buf_full)); // R5

  AST_DONE_SETS_RX: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> rx_full); // R6

  AST_SCK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (m_act && !busy) |-> (sck_o == cpol)); // R3

  AST_MISO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (s_act && cpha && $past(s_act && cpha) && $stable(ctrl) && !$past(ev)) |-> $stable(miso_o)); // R9
endmodule

bind spi_buffered_ctrl spi_buffered_ctrl_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .fault(fault), .sck_oe(sck_oe), .mosi_oe(mosi_oe),
  .miso_oe(miso_oe), .ss_oe(ss_oe), .buf_full(buf_full), .wr_data(wr_data),
  .tx_arm(tx_arm), .done(done), .rx_full(rx_full), .m_act(m_act), .s_act(s_act),
  .busy(busy), .ecnt(ecnt), .cpha(cpha), .cpol(cpol), .ctrl(ctrl), .ev(ev),
  .miso_o(miso_o), .sck_o(sck_o)
);

// File: tb/spi_buffered_ctrl_tb.sv
`timescale 1ns/1ps
module spi_buffered_ctrl_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] reg_sel = '0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic sck_o, sck_oe, mosi_o, mosi_oe, miso_o, miso_oe, ss_o, ss_oe, irq;
  logic sck_i = 1'b0, mosi_i = 1'b0, ss_i = 1'b1;

  always #2.5ns clk = ~clk;

  spi_buffered_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sck_o(sck_o), .sck_oe(sck_oe),
    .sck_i(sck_i), .mosi_o(mosi_o), .mosi_oe(mosi_oe), .mosi_i(mosi_i),
    .miso_i(mosi_o), .miso_o(miso_o), .miso_oe(miso_oe), .ss_o(ss_o), .ss_oe(ss_oe),
    .ss_i(ss_i), .irq(irq)
  );

  int tests = 0, fails = 0, cyc = 0;
  int half = 1, frames = 0, gap_checks = 0;
  bit mon_on = 0, chk_gap = 0, cm_cpha = 0, cm_lsb = 0, done_flag = 0;
  string tag = "R3";
  logic [7:0] exp_q[$];

  task automatic chk(input bit ok, input string t, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", t, act, exp);
    end
  endtask

  always @(posedge clk) cyc++;

  // monitor: decodes MOSI frames and compares with the scoreboard queue
  logic prev_sck = 1'b0;
  int idx = 0, t1 = 0, t16 = 0;
  bit have16 = 0;
  logic [7:0] acc = '0;
  always @(negedge clk) begin
    if (!mon_on || ss_o) begin
      idx = 0; have16 = 0;
    end else if (sck_o != prev_sck) begin
      if (idx == 0 && have16 && chk_gap) begin
        chk(cyc - t16 == 2 * half, "R4 gap", cyc - t16, 2 * half);
        gap_checks++;
      end
      if (idx == 0) t1 = cyc;
      if (idx == 1) chk(cyc - t1 == half, "R10 half-period", cyc - t1, half);
      if (cm_cpha ? (idx % 2 == 1) : (idx % 2 == 0))
        acc = cm_lsb ? {mosi_o, acc[7:1]} : {acc[6:0], mosi_o};
      idx++;
      if (idx == 16) begin
        idx = 0; have16 = 1; t16 = cyc; frames++;
        if (exp_q.size() == 0) chk(0, "R2 unexpected frame", acc, 0);
        else begin
          automatic logic [7:0] e = exp_q.pop_front();
          chk(acc == e, tag, acc, e);
        end
      end
    end
    prev_sck = sck_o;
  end

  task automatic rw(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk); reg_sel = s; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rr(input logic [1:0] s, output logic [7:0] d);
    @(negedge clk); reg_sel = s; reg_rd = 1'b1; #1ns; d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic send(input logic [7:0] b, input bit push);
    logic [7:0] st;
    st = '0;
    while (!st[0]) rr(2'd1, st);
    if (push) exp_q.push_back(b);
    rw(2'd2, b);
  endtask

  task automatic wait_idle();
    repeat (3) @(negedge clk);
    while (!ss_o) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic set_rate(input int r);
    rw(2'd3, 8'(r));
    half = 1 << r;
  endtask

  task automatic finish_all();
    if (!done_flag) begin
      done_flag = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    chk(0, "watchdog", cyc, 0);
    finish_all();
  end

  initial begin
    logic [7:0] d;
    int f0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk({sck_oe, mosi_oe, miso_oe, ss_oe} == 4'b0, "R1 enables", {sck_oe, mosi_oe, miso_oe, ss_oe}, 0);
    chk(irq == 1'b0 && ss_o == 1'b1, "R1 irq/ss", {irq, ss_o}, 1);
    rr(2'd0, d); chk(d == 8'h00, "R1 control", d, 0);

    // R2 unarmed write is dropped
    mon_on = 1;
    set_rate(1);
    rw(2'd0, 8'h23);
    rw(2'd2, 8'h3C);
    f0 = 0;
    repeat (40) begin @(negedge clk); if (!ss_o) f0 = 1; end
    chk(f0 == 0, "R2 no transfer", f0, 0);
    rr(2'd1, d); chk(d == 8'h01, "R1 R2 status", d, 8'h01);

    // R3 mode 0 with loopback, R6 receive handshake
    tag = "R3 mode0";
    send(8'hA5, 1);
    rw(2'd2, 8'h77);           // R2: second write without status read
    wait_idle();
    chk(frames == 1 && exp_q.size() == 0, "R2 frame count", frames, 1);
    rr(2'd2, d); chk(d == 8'hA5, "R6 loopback data", d, 8'hA5);
    rr(2'd1, d); chk(d[1] == 1'b1, "R6 full kept after bare data read", d[1], 1);
    rr(2'd2, d);
    rr(2'd1, d); chk(d[1] == 1'b0, "R6 full cleared", d[1], 0);

    // R3 other modes, R7 lsb first
    for (int m = 1; m < 4; m++) begin
      cm_cpha = m[1]; tag = "R3 mode sweep";
      rw(2'd0, 8'(8'h23 | (m << 2)));
      send(8'(8'h5C + m * 8'h31), 1);
      wait_idle();
    end
    cm_lsb = 1; tag = "R7 lsb";
    for (int m = 0; m < 4; m += 3) begin
      cm_cpha = m[1];
      rw(2'd0, 8'(8'h33 | (m << 2)));
      send(8'hB2, 1);
      wait_idle();
    end
    cm_lsb = 0;
    chk(frames == 6 && exp_q.size() == 0, "R3 R7 frames", frames, 6);

    // R4 back-to-back with phase 1, R10 divider
    set_rate(2); chk_gap = 1; cm_cpha = 1; tag = "R4 data";
    rw(2'd0, 8'h2B);
    f0 = gap_checks;
    send(8'hE1, 1);
    send(8'h5B, 1);
    wait_idle();
    chk(gap_checks == f0 + 1, "R4 select held", gap_checks - f0, 1);

    // R5 write during the first clock pulse
    set_rate(3); tag = "R5 order";
    rw(2'd0, 8'h2F);
    send(8'h96, 1);
    while (sck_o == 1'b1) @(negedge clk);
    send(8'h69, 1);
    rr(2'd1, d); chk(d[0] == 1'b0, "R5 empty low after write", d[0], 0);
    repeat (30) @(negedge clk);
    rr(2'd1, d); chk(d[0] == 1'b0, "R5 still held mid-byte", d[0], 0);
    wait_idle();
    chk(exp_q.size() == 0, "R5 both sent", exp_q.size(), 0);
    chk_gap = 0;

    // R11 interrupt
    set_rate(1); cm_cpha = 0; tag = "R11 data";
    rw(2'd0, 8'h63);
    send(8'h0F, 1);
    wait_idle();
    chk(irq == 1'b1, "R11 rx irq", irq, 1);
    rr(2'd1, d); rr(2'd2, d);
    chk(irq == 1'b0, "R11 irq cleared", irq, 0);
    rw(2'd0, 8'hA3);
    @(negedge clk); chk(irq == 1'b1, "R11 tx irq", irq, 1);

    // R8 mode fault
    mon_on = 0;
    rw(2'd0, 8'h03);
    @(negedge clk); chk(sck_oe == 1'b1, "R8 master driving", sck_oe, 1);
    ss_i = 1'b0;
    repeat (5) @(negedge clk);
    chk({sck_oe, mosi_oe, miso_oe, ss_oe} == 4'b0, "R8 enables off", {sck_oe, mosi_oe, miso_oe, ss_oe}, 0);
    rr(2'd1, d); chk(d[2] == 1'b1, "R8 fault flag", d[2], 1);
    rr(2'd0, d); chk(d[1] == 1'b0, "R8 back to slave", d[1], 0);
    ss_i = 1'b1;
    repeat (4) @(negedge clk);
    rw(2'd0, 8'h01);
    rr(2'd1, d); chk(d[2] == 1'b0, "R8 fault cleared", d[2], 0);

    // R9 slave phase 1, MISO hold
    begin
      logic [7:0] got, tx;
      bit held;
      rw(2'd0, 8'h09);
      send(8'hC3, 0);
      tx = 8'h5A; got = '0;
      ss_i = 1'b0;
      repeat (8) @(negedge clk);
      chk(miso_oe == 1'b1, "R9 miso enabled", miso_oe, 1);
      for (int i = 7; i >= 0; i--) begin
        sck_i = 1'b1; mosi_i = tx[i];
        repeat (8) @(negedge clk);
        got = {got[6:0], miso_o};
        sck_i = 1'b0;
        repeat (8) @(negedge clk);
      end
      chk(got == 8'hC3, "R9 slave data", got, 8'hC3);
      held = 1;
      fork
        repeat (40) begin @(negedge clk); if (miso_o != 1'b1) held = 0; end
        send(8'h3C, 0);
      join
      chk(held == 1, "R9 miso held", held, 1);
      rr(2'd1, d); rr(2'd2, d);
      chk(d == 8'h5A, "R9 R6 slave receive", d, 8'h5A);
      ss_i = 1'b1;
    end
    repeat (5) @(negedge clk);
    finish_all();
  end
endmodule